// File: doc/BRIEF.md
# Transmit Packet Queue with Completion Return

This block sits between a host driver and a frame transmit engine and keeps track of which packets are waiting to be sent and which have finished. The host places a packet number on `pkt_num` and issues an enqueue command. The block hands queued numbers to the engine one at a time, oldest first. The engine reports the outcome of each attempt. A collision leads to a retry of the same packet. A finished packet moves into a second queue, where the host can read it and then drop it.

When auto-release is on, a packet that was sent successfully skips the completion queue. Its number is handed straight to the buffer allocator on a release strobe. If one packet fails on sixteen attempts in a row, transmit enable drops and the packet goes to the completion queue so the host can inspect it. Nothing new is started until the host sets transmit enable again.

Two status bits summarise the queues. `tx_int` is high while finished packets are waiting for the host. `tx_empty` is high while nothing is queued for transmission.

Top module: `tx_pkt_queue`

## Requirements
- R1: `host_cmd_valid` with `host_cmd` = 3'b110 appends `pkt_num` to the transmit queue. Codes other than 3'b110 and 3'b111 change nothing.
- R2: `host_cmd_valid` with `host_cmd` = 3'b111 empties both queues, clears `enq_overflow` and abandons any packet in flight. A later `xmit_done` for that packet is ignored.
- R3: `tx_int` is 1 exactly when the completion queue holds at least one entry. `tx_empty` is 1 exactly when the transmit queue holds none.
- R4: `xmit_start` pulses for one cycle, with `xmit_pkt` equal to the oldest queued number, when all four of these hold: transmit enable is 1, the transmit queue is non-empty, the completion queue has a free slot and no packet is in flight. Packets start in enqueue order.
- R5: An `xmit_done` with `xmit_ok`=0 that is not the sixteenth failure restarts the same packet. `xmit_start` is high in the cycle after the report.
- R6: On the sixteenth failed attempt of one packet, `tx_enable` drops to 0 and the packet number is pushed to the completion queue. No packet starts until a `tx_en_set` pulse.
- R7: With `auto_release`=0, a successful packet is pushed to the completion queue, in completion order.
- R8: With `auto_release`=1, a successful packet is not pushed to the completion queue. `release_valid` is high for the single cycle after the report, with `release_pkt` equal to the packet number.
- R9: The transmit queue holds 4 entries. An enqueue into a full queue is dropped and sets the sticky `enq_overflow`.
- R10: `done_head` shows the oldest completion entry and `done_pop` removes it. A pop from an empty completion queue has no effect.
- R11: A completion push and a `done_pop` in the same cycle leave the completion count unchanged and keep the entries in order.
- R12: After reset both queues are empty, transmit enable is 0, and `enq_overflow` and `release_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_valid | input | 1 | Host command strobe |
| host_cmd | input | 3 | Command code (3'b110 enqueue, 3'b111 flush) |
| pkt_num | input | 5 | Packet number to enqueue |
| tx_en_set | input | 1 | Host pulse setting transmit enable |
| auto_release | input | 1 | Release successful packets instead of queuing them |
| done_pop | input | 1 | Remove the head of the completion queue |
| xmit_done | input | 1 | Engine reports the end of an attempt |
| xmit_ok | input | 1 | Attempt succeeded (valid with xmit_done) |
| tx_enable | output | 1 | Transmit enable state |
| tx_int | output | 1 | Completion queue not empty |
| tx_empty | output | 1 | Transmit queue empty |
| enq_overflow | output | 1 | Sticky flag for a dropped enqueue |
| done_head | output | 5 | Oldest completion entry |
| xmit_start | output | 1 | Start request to the engine |
| xmit_pkt | output | 5 | Packet number to send |
| release_valid | output | 1 | Release strobe to the allocator |
| release_pkt | output | 5 | Packet number being released |

## Verification
The bench goes after the exact retry limit. A design off by one on the limit either drops transmit enable after fifteen failures or starts a seventeenth attempt. The bench also checks that a packet finishing while the completion queue is being popped is neither lost nor duplicated, and that a full completion queue holds back the next start instead of overwriting an entry. Further checks confirm that a flush during a transmission throws away the late result, that an unknown command code does not enqueue, and that auto-release both produces the release strobe and leaves `tx_int` low.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam logic [2:0] CMD_ENQUEUE = 3'b110;
  localparam logic [2:0] CMD_FLUSH   = 3'b111;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_BUSY     = 2'd1,
    SQ_RELAUNCH = 2'd2
  } seq_state_t;

  // Circular pointer advance for a queue of any depth.
  function automatic int ptr_step(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int occ_next(input int occ, input bit push_ok, input bit pop_ok);
    return occ + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
  endfunction

  // True when one more failure reaches the attempt limit.
  function automatic bit last_try(input int fails, input int max_tries);
    return (fails + 1) >= max_tries;
  endfunction

endpackage

// File: rtl/pnum_fifo.sv
module pnum_fifo
  import txq_pkg::*;
#(
  parameter int W     = 5,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] occ;
  logic          pop_ok;

  assign empty   = (occ == '0);
  assign full    = (occ == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = mem[rd_ptr];
  assign count   = occ;

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
      occ <= CW'(occ_next(int'(occ), push_ok, pop_ok));
    end
  end

  // R11: simultaneous accepted push and pop keep occupancy
  a_r11_push_pop_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !flush) |=> $stable(count));

  // R9: a push into a full queue without a pop is dropped
  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full && !flush) |=> (count == CW'(DEPTH)));

  // R10: pop on empty has no effect
  a_r10_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !flush) |=> (count == '0));

  // R2: flush empties the queue
  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/txq_sequencer.sv
module txq_sequencer
  import txq_pkg::*;
#(
  parameter int PW           = 5,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          en_set,
  input  logic          txq_empty,
  input  logic [PW-1:0] txq_head,
  input  logic          cq_full,
  input  logic          xmit_done,
  input  logic          xmit_ok,
  output logic          tx_en,
  output logic          xmit_start,
  output logic [PW-1:0] xmit_pkt,
  output logic          fin_ok,
  output logic          fin_fail
);

  localparam int FW = $clog2(MAX_ATTEMPTS + 1);

  seq_state_t    state, state_nx;
  logic [FW-1:0] fails;
  logic          done_evt, att_fail, final_try, launch_idle;

  assign launch_idle = (state == SQ_IDLE) && tx_en && !txq_empty && !cq_full;
  assign xmit_start  = launch_idle || (state == SQ_RELAUNCH);
  assign xmit_pkt    = txq_head;

  assign done_evt  = (state == SQ_BUSY) && xmit_done && !flush;
  assign final_try = last_try(int'(fails), MAX_ATTEMPTS);
  assign fin_ok    = done_evt && xmit_ok;
  assign att_fail  = done_evt && !xmit_ok;
  assign fin_fail  = att_fail && final_try;

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:     if (launch_idle) state_nx = SQ_BUSY;
      SQ_RELAUNCH: state_nx = SQ_BUSY;
      SQ_BUSY: begin
        if (fin_ok || fin_fail) state_nx = SQ_IDLE;
        else if (att_fail)      state_nx = SQ_RELAUNCH;
      end
      default:     state_nx = SQ_IDLE;
    endcase
    if (flush) state_nx = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      fails <= '0;
      tx_en <= 1'b0;
    end else begin
      state <= state_nx;
      if (flush || fin_ok || fin_fail) fails <= '0;
      else if (att_fail)               fails <= fails + FW'(1);
      if (fin_fail)    tx_en <= 1'b0;
      else if (en_set) tx_en <= 1'b1;
    end
  end

  // R5: a non-final failure restarts the same packet next cycle
  a_r5_retry_same_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (att_fail && !final_try) |=> (xmit_start && xmit_pkt == $past(txq_head)));

  // R6: the final failure drops transmit enable
  a_r6_fail_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fail |=> !tx_en);

  // R4: no start while a packet is in flight
  a_r4_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BUSY) |-> !xmit_start);

  // R2: flush returns the sequencer to idle
  a_r2_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state == SQ_IDLE));

endmodule

// File: rtl/tx_pkt_queue.sv
module tx_pkt_queue
  import txq_pkg::*;
#(
  parameter int PKT_W        = 5,
  parameter int DEPTH        = 4,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cmd_valid,
  input  logic [2:0]       host_cmd,
  input  logic [PKT_W-1:0] pkt_num,
  input  logic             tx_en_set,
  input  logic             auto_release,
  input  logic             done_pop,
  input  logic             xmit_done,
  input  logic             xmit_ok,
  output logic             tx_enable,
  output logic             tx_int,
  output logic             tx_empty,
  output logic             enq_overflow,
  output logic [PKT_W-1:0] done_head,
  output logic             xmit_start,
  output logic [PKT_W-1:0] xmit_pkt,
  output logic             release_valid,
  output logic [PKT_W-1:0] release_pkt
);

  localparam int CW = $clog2(DEPTH + 1);

  logic             enq_cmd, flush_cmd;
  logic             fin_ok, fin_fail;
  logic             txq_pop, txq_full, txq_empty, txq_push_ok;
  logic [PKT_W-1:0] txq_head;
  logic [CW-1:0]    txq_count;
  logic             cq_push, cq_full, cq_empty, cq_push_ok;
  logic [CW-1:0]    cq_count;

  assign enq_cmd   = host_cmd_valid && (host_cmd == CMD_ENQUEUE);
  assign flush_cmd = host_cmd_valid && (host_cmd == CMD_FLUSH);
  assign txq_pop   = fin_ok || fin_fail;
  assign cq_push   = fin_fail || (fin_ok && !auto_release);

  pnum_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_cmd),
    .push      (enq_cmd),
    .push_data (pkt_num),
    .pop       (txq_pop),
    .head      (txq_head),
    .count     (txq_count),
    .full      (txq_full),
    .empty     (txq_empty),
    .push_ok   (txq_push_ok)
  );

  pnum_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_cq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_cmd),
    .push      (cq_push),
    .push_data (txq_head),
    .pop       (done_pop),
    .head      (done_head),
    .count     (cq_count),
    .full      (cq_full),
    .empty     (cq_empty),
    .push_ok   (cq_push_ok)
  );

  txq_sequencer #(.PW(PKT_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_cmd),
    .en_set     (tx_en_set),
    .txq_empty  (txq_empty),
    .txq_head   (txq_head),
    .cq_full    (cq_full),
    .xmit_done  (xmit_done),
    .xmit_ok    (xmit_ok),
    .tx_en      (tx_enable),
    .xmit_start (xmit_start),
    .xmit_pkt   (xmit_pkt),
    .fin_ok     (fin_ok),
    .fin_fail   (fin_fail)
  );

  assign tx_int   = !cq_empty;
  assign tx_empty = txq_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_overflow  <= 1'b0;
      release_valid <= 1'b0;
      release_pkt   <= '0;
    end else begin
      if (flush_cmd)                   enq_overflow <= 1'b0;
      else if (enq_cmd && !txq_push_ok) enq_overflow <= 1'b1;
      release_valid <= fin_ok && auto_release;
      if (fin_ok && auto_release) release_pkt <= txq_head;
    end
  end

  // R1: an accepted enqueue grows the transmit queue by one
  a_r1_enqueue_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_cmd && !txq_full && !txq_pop) |=> (txq_count == $past(txq_count) + CW'(1)));

  // R9: a dropped enqueue raises the overflow flag
  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_cmd && txq_full && !txq_pop) |=> enq_overflow);

  // R3: a completion push raises the transmit interrupt
  a_r3_push_raises_int: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_push && !flush_cmd) |=> tx_int);

  // R8: auto-release strobes the allocator and leaves the completion queue alone
  a_r8_release_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ok && auto_release) |=> (release_valid && release_pkt == $past(txq_head)));

  a_r8_cq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ok && auto_release && !done_pop && !flush_cmd) |=> (cq_count == $past(cq_count)));

  // R4: a push never finds the completion queue without room
  a_r4_cq_room: assert property (@(posedge clk) disable iff (!rst_n)
    cq_push |-> (cq_push_ok || flush_cmd));

endmodule

// File: tb/tx_pkt_queue_bench.sv
`timescale 1ns/1ps
module tx_pkt_queue_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cmd_valid = 1'b0;
  logic [2:0] host_cmd = 3'b000;
  logic [4:0] pkt_num = '0;
  logic       tx_en_set = 1'b0;
  logic       auto_release = 1'b0;
  logic       done_pop = 1'b0;
  logic       xmit_done = 1'b0;
  logic       xmit_ok = 1'b0;
  logic       tx_enable, tx_int, tx_empty, enq_overflow;
  logic [4:0] done_head, xmit_pkt, release_pkt;
  logic       xmit_start, release_valid;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  localparam int LIMIT = 16;

  always #2 clk = ~clk;

  tx_pkt_queue u_tx_pkt_queue (
    .clk(clk), .rst_n(rst_n), .host_cmd_valid(host_cmd_valid), .host_cmd(host_cmd),
    .pkt_num(pkt_num), .tx_en_set(tx_en_set), .auto_release(auto_release),
    .done_pop(done_pop), .xmit_done(xmit_done), .xmit_ok(xmit_ok),
    .tx_enable(tx_enable), .tx_int(tx_int), .tx_empty(tx_empty),
    .enq_overflow(enq_overflow), .done_head(done_head), .xmit_start(xmit_start),
    .xmit_pkt(xmit_pkt), .release_valid(release_valid), .release_pkt(release_pkt)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] code, input logic [4:0] p);
    host_cmd_valid = 1'b1; host_cmd = code; pkt_num = p;
    step();
    host_cmd_valid = 1'b0;
  endtask

  task automatic set_enable();
    tx_en_set = 1'b1;
    step();
    tx_en_set = 1'b0;
  endtask

  task automatic pop_done();
    done_pop = 1'b1;
    step();
    done_pop = 1'b0;
  endtask

  task automatic expect_start(input string req, input int p);
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (xmit_start) begin seen = 1; break; end
      step();
    end
    chk(req, "start seen", seen, 1);
    chk(req, "start packet", int'(xmit_pkt), p);
  endtask

  // Start must be visible on entry. Runs nfail failed attempts then,
  // if ok_end, one successful attempt.
  task automatic run_pkt(input int p, input int nfail, input bit ok_end,
                         input bit enq_in, input logic [4:0] enq_p, input bit pop_last);
    int tries = nfail + (ok_end ? 1 : 0);
    for (int a = 0; a < tries; a++) begin
      if (a == 0 && enq_in) begin
        host_cmd_valid = 1'b1; host_cmd = 3'b110; pkt_num = enq_p;
      end
      step();
      host_cmd_valid = 1'b0;
      xmit_done = 1'b1;
      xmit_ok = (a == tries - 1) && ok_end;
      if (a == tries - 1 && pop_last) done_pop = 1'b1;
      step();
      xmit_done = 1'b0; xmit_ok = 1'b0; done_pop = 1'b0;
      if (a < tries - 1) begin
        chk("R5", "retry start", int'(xmit_start), 1);
        chk("R5", "retry packet", int'(xmit_pkt), p);
      end
    end
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R12 reset state
    chk("R12", "tx_empty", int'(tx_empty), 1);
    chk("R12", "tx_int", int'(tx_int), 0);
    chk("R12", "tx_enable", int'(tx_enable), 0);
    chk("R12", "enq_overflow", int'(enq_overflow), 0);
    chk("R12", "release_valid", int'(release_valid), 0);

    // R1 enqueue with transmit disabled; unknown code ignored
    cmd(3'b110, 5'd5);
    chk("R1", "tx_empty after enqueue", int'(tx_empty), 0);
    cmd(3'b110, 5'd9);
    cmd(3'b110, 5'd17);
    cmd(3'b010, 5'd3);
    cmd(3'b110, 5'd21);
    chk("R9", "no overflow at four", int'(enq_overflow), 0);
    cmd(3'b110, 5'd30);
    chk("R9", "overflow on fifth", int'(enq_overflow), 1);
    chk("R4", "no start while disabled", int'(xmit_start), 0);
    step(); step();
    chk("R4", "still no start", int'(xmit_start), 0);

    // R4 R7 ordered launch and completion
    set_enable();
    chk("R6", "enable set", int'(tx_enable), 1);
    expect_start("R4", 5);
    run_pkt(5, 0, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R3", "tx_int after first done", int'(tx_int), 1);
    chk("R7", "completion head", int'(done_head), 5);
    expect_start("R4", 9);
    run_pkt(9, 0, 1'b1, 1'b0, 5'd0, 1'b0);
    expect_start("R4", 17);
    run_pkt(17, 3, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R5", "enable kept after retries", int'(tx_enable), 1);
    expect_start("R9", 21);
    run_pkt(21, 0, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R9", "dropped packet never queued", int'(tx_empty), 1);
    chk("R7", "head still oldest", int'(done_head), 5);

    // R4 full completion queue holds the next start back
    cmd(3'b110, 5'd2);
    for (int i = 0; i < 5; i++) begin
      chk("R4", "held by full completion queue", int'(xmit_start), 0);
      step();
    end
    pop_done();
    chk("R10", "head after pop", int'(done_head), 9);
    expect_start("R4", 2);

    // R11 completion push together with host pop
    run_pkt(2, 0, 1'b1, 1'b0, 5'd0, 1'b1);
    chk("R11", "head after push+pop", int'(done_head), 17);
    pop_done();
    chk("R11", "second entry", int'(done_head), 21);
    pop_done();
    chk("R11", "pushed entry last", int'(done_head), 2);
    chk("R11", "one entry left", int'(tx_int), 1);
    pop_done();
    chk("R3", "tx_int clear when drained", int'(tx_int), 0);
    pop_done();
    chk("R10", "pop on empty", int'(tx_int), 0);

    // R8 auto-release
    auto_release = 1'b1;
    cmd(3'b110, 5'd7);
    expect_start("R8", 7);
    run_pkt(7, 0, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R8", "release strobe", int'(release_valid), 1);
    chk("R8", "release packet", int'(release_pkt), 7);
    chk("R8", "no completion entry", int'(tx_int), 0);
    step();
    chk("R8", "strobe one cycle", int'(release_valid), 0);

    // R6 excessive failures halt the queue
    cmd(3'b110, 5'd11);
    expect_start("R6", 11);
    run_pkt(11, LIMIT, 1'b0, 1'b1, 5'd12, 1'b0);
    chk("R6", "enable cleared", int'(tx_enable), 0);
    chk("R6", "failed packet in completion", int'(tx_int), 1);
    chk("R6", "failed packet number", int'(done_head), 11);
    chk("R6", "no release on failure", int'(release_valid), 0);
    chk("R6", "next packet waiting", int'(tx_empty), 0);
    for (int i = 0; i < 6; i++) begin
      chk("R6", "halted", int'(xmit_start), 0);
      step();
    end
    set_enable();
    expect_start("R6", 12);
    run_pkt(12, 0, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R8", "release after restart", int'(release_pkt), 12);
    chk("R6", "failed entry kept", int'(done_head), 11);

    // R2 flush during a transmission
    auto_release = 1'b0;
    step();
    cmd(3'b110, 5'd13);
    expect_start("R2", 13);
    cmd(3'b110, 5'd14);
    chk("R2", "queue non-empty before flush", int'(tx_empty), 0);
    chk("R9", "overflow sticky", int'(enq_overflow), 1);
    cmd(3'b111, 5'd0);
    chk("R2", "tx queue emptied", int'(tx_empty), 1);
    chk("R2", "completion emptied", int'(tx_int), 0);
    chk("R2", "overflow cleared", int'(enq_overflow), 0);
    chk("R2", "no start after flush", int'(xmit_start), 0);
    xmit_done = 1'b1; xmit_ok = 1'b1;
    step();
    xmit_done = 1'b0; xmit_ok = 1'b0;
    chk("R2", "late done ignored", int'(tx_int), 0);
    chk("R2", "late done no release", int'(release_valid), 0);
    cmd(3'b110, 5'd6);
    expect_start("R2", 6);

    finish_run();
  end

endmodule